// File: doc/BRIEF.md
# Two's-Complement Fixed-Point Execution Unit

This unit carries out signed 32-bit fixed-point arithmetic on two's-complement words. It supports add, subtract, negate, algebraic shifts left and right, and a signed 32x32 multiply that returns a 64-bit product. Overflow follows architected rules rather than plain wrap-around:

- Negating the most negative value raises overflow and returns that value unchanged.
- An algebraic left shift never alters the sign bit. It raises overflow when significant bits are lost.

The surrounding pipeline presents one request at a time on a valid/ready pair. A request carries a 3-bit opcode, two operands and a 6-bit shift count.

- Add, subtract, negate and shift finish in one clock.
- Multiply is iterative and holds ready low while it works.

Every result appears as a one-cycle `res_valid` pulse. The result is delivered as a double-length pair: the low word, plus a high word that is either the product's upper half or the sign extension of the low word. The pulse also carries an overflow flag and a 2-bit condition code. The unit only reports overflow and takes no trap action.

Top module: `fxu_top`

## Requirements
- R1: Opcode 0 (add) returns the low 32 bits of `opnd_a + opnd_b`. `ovf` is 1 exactly when the true sum lies outside [-2^31, 2^31-1]. On overflow the delivered sign bit is the inverse of the true result's sign.
- R2: Opcode 1 (subtract) returns the low 32 bits of `opnd_a - opnd_b`. `ovf` is 1 only when the true difference is out of range. For example, -1 minus any value never overflows.
- R3: Opcode 2 (negate) returns `-opnd_b`. When `opnd_b` is 0x80000000, `ovf` is 1 and the result is 0x80000000.
- R4: Opcode 3 (algebraic left shift) shifts `opnd_a` left by `shamt` (0 to 63) and fills zeros from the right.
  - Bit 31 of the result always equals bit 31 of `opnd_a`.
  - `ovf` is 1 when any bit shifted out past bit 30 differs from the sign.
- R5: Opcode 4 (algebraic right shift) shifts `opnd_a` right by `shamt` and fills copies of the sign. Counts of 31 or more give all-sign words. `ovf` is always 0.
- R6: For opcodes 0 to 4, `cc` is 3 on overflow. Otherwise it is 0 for a zero result, 1 for a negative result and 2 for a positive result.
- R7: For opcodes 0 to 4, `res_hi` equals 32 copies of bit 31 of `res_lo`.
- R8: An accepted opcode 0 to 4 raises `res_valid` for exactly the cycle after the accepting edge, with its result.
- R9: Opcode 5 (multiply) delivers the signed 64-bit product as {`res_hi`,`res_lo`}, with `ovf` 0 and `cc` unchanged.
  - `res_valid` rises 32 clock edges after the accepting edge.
  - 0x80000000 times itself gives 0x4000000000000000.
- R10: From the edge that accepts a multiply until the edge that delivers its product, `op_ready` is 0 and requests offered meanwhile are not taken.
- R11: After synchronous reset, `res_valid`, `ovf`, `cc`, `res_lo` and `res_hi` are 0 and `op_ready` is 1.
- R12: Opcodes 6 and 7 are accepted but produce no `res_valid` and leave `res_lo`, `res_hi`, `ovf` and `cc` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request present |
| op_ready | output | 1 | Unit can take a request this cycle |
| op_code | input | 3 | 0 add, 1 sub, 2 negate, 3 left shift, 4 right shift, 5 multiply |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (negate uses this one) |
| shamt | input | 6 | Shift count |
| res_valid | output | 1 | One-cycle result strobe |
| res_lo | output | 32 | Result, or low half of product |
| res_hi | output | 32 | Sign extension of result, or high half of product |
| ovf | output | 1 | Fixed-point overflow |
| cc | output | 2 | Condition code |

## Verification
Single-cycle operations register their result at the accepting edge. The bench therefore drives each request on a falling edge and samples all outputs on the very next falling edge, one register stage later. A multiply's product is due 32 edges after acceptance. The bench counts falling edges from acceptance until `res_valid` appears and requires the count to be exactly 33, so an early or late product is caught as a latency error. In some multiply runs, requests are held on the inputs throughout. This shows that nothing is taken while ready is low, and that no extra strobe follows the product.

// File: rtl/fxu_pkg.sv
package fxu_pkg;

    localparam int FX_W   = 32;
    localparam int FX_SHW = 6;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_NEG = 3'd2,
        OP_SLA = 3'd3,
        OP_SRA = 3'd4,
        OP_MUL = 3'd5,
        OP_RS6 = 3'd6,
        OP_RS7 = 3'd7
    } fx_op_e;

    typedef enum logic [1:0] {
        CC_ZERO = 2'd0,
        CC_NEG  = 2'd1,
        CC_POS  = 2'd2,
        CC_OVF  = 2'd3
    } fx_cc_e;

    typedef struct packed {
        logic   ovf;
        fx_cc_e cc;
    } fx_flags_t;

    function automatic fx_cc_e cc_of(input logic is_zero, input logic is_neg, input logic ovf);
        if (ovf)          return CC_OVF;
        else if (is_zero) return CC_ZERO;
        else if (is_neg)  return CC_NEG;
        else              return CC_POS;
    endfunction

    function automatic logic is_single(input fx_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_NEG) ||
               (op == OP_SLA) || (op == OP_SRA);
    endfunction

endpackage

// File: rtl/fxu_addsub.sv
module fxu_addsub
    import fxu_pkg::*;
#(
    parameter int W = FX_W
) (
    input  fx_op_e         op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           ovf
);
    logic [W-1:0] lhs;
    logic [W-1:0] rhs;
    logic [W-1:0] cin;

    // one adder for all three: negate is 0 - b, subtract adds ~b + 1
    always_comb begin
        lhs = (op == OP_NEG) ? '0 : a;
        rhs = (op == OP_ADD) ? b : ~b;
        cin = (op == OP_ADD) ? '0 : W'(1);
        y   = lhs + rhs + cin;
        // overflow: like-signed inputs whose sum changes sign
        ovf = (lhs[W-1] == rhs[W-1]) && (y[W-1] != lhs[W-1]);
    end
endmodule

// File: rtl/fxu_shift.sv
module fxu_shift #(
    parameter int W   = fxu_pkg::FX_W,
    parameter int SHW = fxu_pkg::FX_SHW
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] n,
    input  logic           left,
    output logic [W-1:0]   y,
    output logic           ovf
);
    localparam int XW = W + (1 << SHW);

    logic [XW-1:0]   ext;
    logic [XW-1:0]   wide;
    logic [XW-W:0]   lost;
    logic            sgn;
    logic [W-1:0]    y_l;
    logic [W-1:0]    y_r;

    always_comb begin
        sgn  = a[W-1];
        ext  = {{(XW-W){sgn}}, a};
        wide = ext << n;
        // everything at or above the sign position must still be sign copies
        lost = wide[XW-1:W-1];
        y_l  = {sgn, wide[W-2:0]};
        y_r  = $unsigned($signed(a) >>> n);
        y    = left ? y_l : y_r;
        ovf  = left && (lost != {(XW-W+1){sgn}});
    end
endmodule

// File: rtl/fxu_mul.sv
module fxu_mul #(
    parameter int W = fxu_pkg::FX_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] prod
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [CW-1:0]  cnt;
    logic [2*W-1:0] mcand_sh;
    logic [W-1:0]   mplier;
    logic [2*W-1:0] acc;
    logic [2*W-1:0] acc_nxt;
    logic           neg;
    logic           last;
    logic [W-1:0]   mag_a;
    logic [W-1:0]   mag_b;

    // magnitudes fit unsigned W bits, including the most negative value
    always_comb begin
        mag_a   = a[W-1] ? (~a + W'(1)) : a;
        mag_b   = b[W-1] ? (~b + W'(1)) : b;
        acc_nxt = acc + (mplier[0] ? mcand_sh : '0);
        last    = (cnt == CW'(W-1));
        done    = busy && last;
        prod    = neg ? (~acc_nxt + (2*W)'(1)) : acc_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            mcand_sh <= '0;
            mplier   <= '0;
            acc      <= '0;
            neg      <= 1'b0;
        end else if (start && !busy) begin
            busy     <= 1'b1;
            cnt      <= '0;
            mcand_sh <= {{W{1'b0}}, mag_a};
            mplier   <= mag_b;
            acc      <= '0;
            neg      <= a[W-1] ^ b[W-1];
        end else if (busy) begin
            acc      <= acc_nxt;
            mcand_sh <= mcand_sh << 1;
            mplier   <= mplier >> 1;
            cnt      <= cnt + CW'(1);
            if (last) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/fxu_top.sv
module fxu_top
    import fxu_pkg::*;
#(
    parameter int W   = FX_W,
    parameter int SHW = FX_SHW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           op_valid,
    output logic           op_ready,
    input  logic [2:0]     op_code,
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    input  logic [SHW-1:0] shamt,
    output logic           res_valid,
    output logic [W-1:0]   res_lo,
    output logic [W-1:0]   res_hi,
    output logic           ovf,
    output logic [1:0]     cc
);
    fx_op_e         op;
    logic           accept;
    logic           take_single;
    logic           take_mul;

    logic [W-1:0]   as_y;
    logic           as_ovf;
    logic [W-1:0]   sh_y;
    logic           sh_ovf;
    logic [W-1:0]   sel_y;
    fx_flags_t      sel_f;

    logic           mul_busy;
    logic           mul_done;
    logic [2*W-1:0] mul_prod;

    fx_flags_t      flags_q;

    assign op          = fx_op_e'(op_code);
    assign op_ready    = !mul_busy;
    assign accept      = op_valid && op_ready;
    assign take_single = accept && is_single(op);
    assign take_mul    = accept && (op == OP_MUL);

    fxu_addsub #(.W(W)) u_addsub (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .y   (as_y),
        .ovf (as_ovf)
    );

    fxu_shift #(.W(W), .SHW(SHW)) u_shift (
        .a    (opnd_a),
        .n    (shamt),
        .left (op == OP_SLA),
        .y    (sh_y),
        .ovf  (sh_ovf)
    );

    fxu_mul #(.W(W)) u_mul (
        .clk   (clk),
        .rst   (rst),
        .start (take_mul),
        .a     (opnd_a),
        .b     (opnd_b),
        .busy  (mul_busy),
        .done  (mul_done),
        .prod  (mul_prod)
    );

    always_comb begin
        if (op == OP_SLA || op == OP_SRA) begin
            sel_y     = sh_y;
            sel_f.ovf = sh_ovf;
        end else begin
            sel_y     = as_y;
            sel_f.ovf = as_ovf;
        end
        sel_f.cc = cc_of(sel_y == '0, sel_y[W-1], sel_f.ovf);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_lo    <= '0;
            res_hi    <= '0;
            flags_q   <= '{ovf: 1'b0, cc: CC_ZERO};
        end else if (mul_done) begin
            res_valid   <= 1'b1;
            res_lo      <= mul_prod[W-1:0];
            res_hi      <= mul_prod[2*W-1:W];
            flags_q.ovf <= 1'b0;
        end else if (take_single) begin
            res_valid <= 1'b1;
            res_lo    <= sel_y;
            res_hi    <= {W{sel_y[W-1]}};
            flags_q   <= sel_f;
        end else begin
            res_valid <= 1'b0;
        end
    end

    assign ovf = flags_q.ovf;
    assign cc  = flags_q.cc;
endmodule

// File: rtl/fxu_top_chk.sv
module fxu_top_chk #(
    parameter int W   = 32,
    parameter int SHW = 6
) (
    input logic           clk,
    input logic           rst,
    input logic           op_valid,
    input logic           op_ready,
    input logic [2:0]     op_code,
    input logic [W-1:0]   opnd_a,
    input logic [W-1:0]   opnd_b,
    input logic [SHW-1:0] shamt,
    input logic           res_valid,
    input logic [W-1:0]   res_lo,
    input logic [W-1:0]   res_hi,
    input logic           ovf,
    input logic [1:0]     cc,
    input logic           mul_done
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic acc_q;
    assign acc_q = op_valid && op_ready;

    AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (acc_q && op_code <= 3'd4) |=> res_valid);                                 // R8

    AST_NEG_MOST: assert property (@(posedge clk) disable iff (rst)
        (acc_q && op_code == 3'd2 && opnd_b == MOST_NEG) |=> (ovf && res_lo == MOST_NEG)); // R3

    AST_SLA_SIGN: assert property (@(posedge clk) disable iff (rst)
        (acc_q && op_code == 3'd3) |=> (res_lo[W-1] == $past(opnd_a[W-1])));      // R4

    AST_SRA_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        (acc_q && op_code == 3'd4) |=> !ovf);                                      // R5

    AST_OVF_CODE: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (cc == 2'd3));                                                     // R6

    AST_HI_EXT: assert property (@(posedge clk) disable iff (rst)
        (acc_q && op_code <= 3'd4) |=> (res_hi == {W{res_lo[W-1]}}));              // R7

    AST_MUL_FLAGS: assert property (@(posedge clk) disable iff (rst)
        mul_done |=> ($stable(cc) && !ovf && res_valid));                          // R9

    AST_MUL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (acc_q && op_code == 3'd5) |=> !op_ready);                                 // R10

    AST_BAD_OP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (acc_q && op_code >= 3'd6) |=> (!res_valid && $stable(cc) && $stable(res_lo))); // R12
endmodule

bind fxu_top fxu_top_chk #(.W(W), .SHW(SHW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .op_code   (op_code),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .shamt     (shamt),
    .res_valid (res_valid),
    .res_lo    (res_lo),
    .res_hi    (res_hi),
    .ovf       (ovf),
    .cc        (cc),
    .mul_done  (mul_done)
);

// File: tb/fxu_top_tb.sv
module fxu_top_tb;
    localparam int W          = 32;
    localparam int SHW        = 6;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 150000;

    logic           clk;
    logic           rst;
    logic           op_valid;
    logic           op_ready;
    logic [2:0]     op_code;
    logic [W-1:0]   opnd_a;
    logic [W-1:0]   opnd_b;
    logic [SHW-1:0] shamt;
    logic           res_valid;
    logic [W-1:0]   res_lo;
    logic [W-1:0]   res_hi;
    logic           ovf;
    logic [1:0]     cc;

    int checks = 0;
    int fails  = 0;

    fxu_top #(.W(W), .SHW(SHW)) u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
        .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt),
        .res_valid(res_valid), .res_lo(res_lo), .res_hi(res_hi),
        .ovf(ovf), .cc(cc)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // arithmetic reference for add / sub / negate
    function automatic void m_arith(input int op, input logic [31:0] a, input logic [31:0] b,
                                    output logic [31:0] r, output bit o);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint t;
        case (op)
            0:       t = sa + sb;
            1:       t = sa - sb;
            default: t = -sb;
        endcase
        o = (t > 64'sd2147483647) || (t < -64'sd2147483648);
        r = t[31:0];
    endfunction

    // bit-serial reference for left shift: sign pinned, compare each lost bit
    function automatic void m_sla(input logic [31:0] a, input int n, output logic [31:0] r, output bit o);
        logic        s = a[31];
        logic [30:0] m = a[30:0];
        o = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (m[30] != s) o = 1'b1;
            m = {m[29:0], 1'b0};
        end
        r = {s, m};
    endfunction

    function automatic logic [31:0] m_sra(input logic [31:0] a, input int n);
        logic [31:0] v = a;
        for (int i = 0; i < n; i++) v = {v[31], v[31:1]};
        return v;
    endfunction

    function automatic logic [1:0] m_cc(input logic [31:0] r, input bit o);
        if (o)          return 2'd3;
        if (r == 32'd0) return 2'd0;
        if (r[31])      return 2'd1;
        return 2'd2;
    endfunction

    task automatic run1(input int op, input logic [31:0] a, input logic [31:0] b, input int n);
        logic [31:0] er;
        bit          eo;
        string       rt;
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = 3'(op);
        opnd_a   = a;
        opnd_b   = b;
        shamt    = SHW'(n);
        @(negedge clk);
        op_valid = 1'b0;
        case (op)
            0: begin m_arith(0, a, b, er, eo); rt = "R1 add"; end
            1: begin m_arith(1, a, b, er, eo); rt = "R2 sub"; end
            2: begin m_arith(2, a, b, er, eo); rt = "R3 neg"; end
            3: begin m_sla(a, n, er, eo);      rt = "R4 sla"; end
            default: begin er = m_sra(a, n); eo = 1'b0; rt = "R5 sra"; end
        endcase
        chk(res_valid == 1'b1, "R8 strobe", 64'(res_valid), 64'd1);
        chk(res_lo == er, {rt, " result"}, 64'(res_lo), 64'(er));
        chk(ovf == eo, {rt, " ovf"}, 64'(ovf), 64'(eo));
        chk(cc == m_cc(er, eo), "R6 cc", 64'(cc), 64'(m_cc(er, eo)));
        chk(res_hi == {32{er[31]}}, "R7 hi", 64'(res_hi), 64'({32{er[31]}}));
    endtask

    task automatic run_mul(input logic [31:0] a, input logic [31:0] b, input bit hammer);
        logic [1:0]  cc0;
        longint      p;
        int          c;
        @(negedge clk);
        cc0      = cc;
        op_valid = 1'b1;
        op_code  = 3'd5;
        opnd_a   = a;
        opnd_b   = b;
        @(negedge clk);
        if (hammer) begin
            op_code = 3'd0;
            opnd_a  = 32'd7;
            opnd_b  = 32'd9;
        end else begin
            op_valid = 1'b0;
        end
        chk(op_ready == 1'b0, "R10 ready low", 64'(op_ready), 64'd0);
        c = 1;
        while (!res_valid && c <= W + 3) begin
            @(negedge clk);
            c++;
        end
        op_valid = 1'b0;
        p = longint'($signed(a)) * longint'($signed(b));
        chk(c == W + 1, "R9 latency", 64'(c - 1), 64'(W));
        chk({res_hi, res_lo} == p, "R9 product", {res_hi, res_lo}, p);
        chk(ovf == 1'b0, "R9 ovf", 64'(ovf), 64'd0);
        chk(cc == cc0, "R9 cc held", 64'(cc), 64'(cc0));
        if (hammer) begin
            @(negedge clk);
            chk(res_valid == 1'b0, "R10 no stray", 64'(res_valid), 64'd0);
        end
    endtask

    logic [31:0] corner [12];

    initial begin
        repeat (WDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] lo0;
        logic [1:0]  cc1;
        corner = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h2, 32'hFFFFFFFE, 32'h7FFFFFFF,
                   32'h80000000, 32'h7FFFFFFE, 32'h80000001, 32'h55555555,
                   32'hAAAAAAAA, 32'h40000000};
        rst = 1'b1; op_valid = 1'b0; op_code = '0; opnd_a = '0; opnd_b = '0; shamt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(res_valid == 1'b0, "R11 valid", 64'(res_valid), 64'd0);
        chk(ovf == 1'b0, "R11 ovf", 64'(ovf), 64'd0);
        chk(cc == 2'd0, "R11 cc", 64'(cc), 64'd0);
        chk({res_hi, res_lo} == 64'd0, "R11 result", {res_hi, res_lo}, 64'd0);
        chk(op_ready == 1'b1, "R11 ready", 64'(op_ready), 64'd1);

        // R1 R2 R9: all corner pairs
        foreach (corner[i]) foreach (corner[j]) begin
            run1(0, corner[i], corner[j], 0);
            run1(1, corner[i], corner[j], 0);
            run_mul(corner[i], corner[j], 1'b0);
        end
        // R3: negate every corner
        foreach (corner[i]) run1(2, 32'h0, corner[i], 0);
        // R4 R5: every count for every corner
        foreach (corner[i]) for (int n = 0; n < 64; n++) begin
            run1(3, corner[i], 32'h0, n);
            run1(4, corner[i], 32'h0, n);
        end
        // R10: requests held during multiply
        run1(0, 32'h80000000, 32'hFFFFFFFF, 0);
        run_mul(32'h80000000, 32'h80000000, 1'b1);
        run_mul(32'h12345678, 32'hFEDCBA98, 1'b1);
        // R12: reserved codes leave state alone
        for (int k = 6; k < 8; k++) begin
            run1(1, 32'h5, 32'h9, 0);
            lo0 = res_lo; cc1 = cc;
            @(negedge clk);
            op_valid = 1'b1; op_code = 3'(k); opnd_a = 32'h3; opnd_b = 32'h3;
            @(negedge clk);
            op_valid = 1'b0;
            chk(res_valid == 1'b0, "R12 no strobe", 64'(res_valid), 64'd0);
            chk(res_lo == lo0, "R12 result held", 64'(res_lo), 64'(lo0));
            chk(cc == cc1, "R12 cc held", 64'(cc), 64'(cc1));
        end
        // random mix
        for (int k = 0; k < 600; k++) begin
            run1(k % 5, $urandom, $urandom, $urandom % 64);
        end
        for (int k = 0; k < 150; k++) begin
            run_mul($urandom, $urandom, k[0]);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule